// File: doc/BRIEF.md
# PWM Output Steering Stage

This block takes a single PWM waveform produced elsewhere and fans it out to four output pins. A four-bit mask decides which pins carry the waveform. Every selected pin shows the same waveform, and every unselected pin sits at its idle level. A two-bit polarity field makes pairs of pins active-high or active-low. A seven-bit count can hold back each inactive-to-active transition by a number of instruction-cycle ticks, which leaves dead time between complementary drivers.

A level-sensitive shutdown input forces the steered pins to their idle level and sets a sticky flag. Recovery can happen in one of two ways. In automatic mode the flag clears as soon as the shutdown input drops. In manual mode the flag stays set until software pulses a clear input. In both modes the pins stay silent until the next PWM period boundary, so no partial pulse reaches them. The period and duty generator, pin direction control and register access all live outside this block.

Top module: `pwm_steer_stage`

## Requirements
- R1: Every pin whose `steerMask` bit is 1 carries the same delayed waveform. In any cycle, the active/idle state is identical across all selected pins.
- R2: A pin whose `steerMask` bit is 0 always drives its idle level.
- R3: Pin index i (A=0, B=1, C=2, D=3) uses polarity bit `polSel[i mod 2]`. When that bit is 0 the pin is active-high (idle 0). When it is 1 the pin is active-low (idle 1). A polarity change shows on `pinOut` in the same cycle.
- R4: With `delayCount` = 0, a pin turns active in the cycle after the clock edge that first samples `pwmIn` high. It returns idle in the cycle after the edge that first samples `pwmIn` low.
- R5: With `delayCount` = D > 0, the count is loaded at the rising-edge sample. The active transition then happens at the D-th later edge on which `tickEn` is 1. With `tickEn` high one clock in four, this is 4·D clocks after the zero-delay position.
- R6: The active-to-inactive transition is never delayed. If the delay does not end while `pwmIn` is still high, the pulse is suppressed entirely.
- R7: An edge that samples `shutdownIn` high sets `shutFlag` and forces every steered pin to its idle level from the next cycle on.
- R8: With `restartAuto` = 1, `shutFlag` clears on the first edge that samples `shutdownIn` low.
- R9: With `restartAuto` = 0, `shutFlag` stays set while `shutdownIn` is low, until an edge samples `flagClear` high.
- R10: After shutdown, pin output resumes only at an edge where `periodStart` is 1 and `shutFlag` was already clear. The first pulse after recovery is therefore whole.
- R11: During and right after reset, `shutFlag` is 0, no delay is pending and all pins are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | Instruction-cycle tick used by the delay counter |
| pwmIn | input | 1 | Source PWM waveform, 1 = active |
| periodStart | input | 1 | One-cycle strobe at each PWM period boundary |
| steerMask | input | 4 | Per-pin steering enable, bit 0 = pin A |
| polSel | input | 2 | Polarity: bit 0 for pins A and C, bit 1 for pins B and D |
| delayCount | input | 7 | Active-edge delay in ticks |
| restartAuto | input | 1 | 1 = flag clears automatically after shutdown |
| shutdownIn | input | 1 | Shutdown request, level sensitive |
| flagClear | input | 1 | Software clear of the shutdown flag |
| pinOut | output | 4 | Steered pin levels, bit 0 = pin A |
| shutFlag | output | 1 | Shutdown status flag |

## Verification
The bench builds the block with its default parameters: four pins, a seven-bit delay and a two-bit polarity field. At this size every one of the 16 steering masks can be swept against all four polarity codes.

The delay is swept from 0 to 12 against a fixed pulse width of 10, which crosses the point where pulses are suppressed, and the largest count of 127 is also tried. The tick-divided timing is checked with `tickEn` high one clock in four. Both recovery modes are walked period by period, so that the resume point at the period boundary can be compared with an arithmetic expectation.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;
  // Strobes passed from the control half to the datapath half
  typedef struct packed {
    logic rise;    // pwmIn seen rising this cycle
    logic low;     // pwmIn currently inactive
    logic tick;    // instruction-cycle tick
    logic outEn;   // output gate (cleared by shutdown)
  } steerStrobes_t;
endpackage

// File: rtl/pwm_steer_ctrl.sv
module pwm_steer_ctrl
  import pwm_steer_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwmIn,
  input  logic          tickEn,
  input  logic          periodStart,
  input  logic          shutdownIn,
  input  logic          restartAuto,
  input  logic          flagClear,
  output steerStrobes_t strb,
  output logic          shutFlag
);
  logic pwmPrev;
  logic flagQ;
  logic runQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwmPrev <= 1'b0;
      flagQ   <= 1'b0;
      runQ    <= 1'b1;
    end else begin
      pwmPrev <= pwmIn;
      // sticky shutdown flag with two recovery styles
      if (shutdownIn)
        flagQ <= 1'b1;
      else if (restartAuto || flagClear)
        flagQ <= 1'b0;
      // output gate: closes at once, reopens only on a period boundary
      if (shutdownIn)
        runQ <= 1'b0;
      else if (periodStart && !flagQ)
        runQ <= 1'b1;
    end
  end

  always_comb begin
    strb.rise  = pwmIn & ~pwmPrev;
    strb.low   = ~pwmIn;
    strb.tick  = tickEn;
    strb.outEn = runQ;
  end

  assign shutFlag = flagQ;
endmodule

// File: rtl/pwm_steer_dp.sv
module pwm_steer_dp
  import pwm_steer_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int DELAY_W  = 7,
  parameter int POL_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  steerStrobes_t       strb,
  input  logic [DELAY_W-1:0]  delayCount,
  input  logic [NUM_PINS-1:0] steerMask,
  input  logic [POL_W-1:0]    polSel,
  output logic [NUM_PINS-1:0] pinOut
);
  localparam logic [DELAY_W-1:0] CNT_ZERO = '0;
  localparam logic [DELAY_W-1:0] CNT_ONE  = DELAY_W'(1);

  logic [DELAY_W-1:0] cntQ;
  logic               waitQ;
  logic               actQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cntQ  <= CNT_ZERO;
      waitQ <= 1'b0;
      actQ  <= 1'b0;
    end else if (strb.low) begin
      // trailing edge is never held back; a pending delay is dropped
      cntQ  <= CNT_ZERO;
      waitQ <= 1'b0;
      actQ  <= 1'b0;
    end else if (strb.rise) begin
      if (delayCount == CNT_ZERO) begin
        actQ <= 1'b1;
      end else begin
        cntQ  <= delayCount;
        waitQ <= 1'b1;
      end
    end else if (waitQ && strb.tick) begin
      if (cntQ == CNT_ONE) begin
        cntQ  <= CNT_ZERO;
        waitQ <= 1'b0;
        actQ  <= 1'b1;
      end else begin
        cntQ <= cntQ - CNT_ONE;
      end
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic drive;
    assign drive     = actQ & strb.outEn & steerMask[i];
    assign pinOut[i] = drive ^ polSel[i % POL_W];
  end
endmodule

// File: rtl/pwm_steer_stage.sv
module pwm_steer_stage
  import pwm_steer_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int DELAY_W  = 7,
  parameter int POL_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tickEn,
  input  logic                pwmIn,
  input  logic                periodStart,
  input  logic [NUM_PINS-1:0] steerMask,
  input  logic [POL_W-1:0]    polSel,
  input  logic [DELAY_W-1:0]  delayCount,
  input  logic                restartAuto,
  input  logic                shutdownIn,
  input  logic                flagClear,
  output logic [NUM_PINS-1:0] pinOut,
  output logic                shutFlag
);
  steerStrobes_t strb;

  pwm_steer_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwmIn       (pwmIn),
    .tickEn      (tickEn),
    .periodStart (periodStart),
    .shutdownIn  (shutdownIn),
    .restartAuto (restartAuto),
    .flagClear   (flagClear),
    .strb        (strb),
    .shutFlag    (shutFlag)
  );

  pwm_steer_dp #(
    .NUM_PINS (NUM_PINS),
    .DELAY_W  (DELAY_W),
    .POL_W    (POL_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .delayCount (delayCount),
    .steerMask  (steerMask),
    .polSel     (polSel),
    .pinOut     (pinOut)
  );
endmodule

// File: rtl/pwm_steer_checker.sv
module pwm_steer_checker #(
  parameter int NUM_PINS = 4,
  parameter int POL_W    = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] steerMask,
  input logic [POL_W-1:0]    polSel,
  input logic                restartAuto,
  input logic                shutdownIn,
  input logic                flagClear,
  input logic [NUM_PINS-1:0] pinOut,
  input logic                shutFlag
);
  logic [NUM_PINS-1:0] idleLvl;
  logic [NUM_PINS-1:0] actSel;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_idle
    assign idleLvl[i] = polSel[i % POL_W];
  end
  assign actSel = (pinOut ^ idleLvl) & steerMask;

  // R2: pins outside the mask stay idle
  p_unsteered_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((pinOut ^ idleLvl) & ~steerMask) == '0);

  // R1: all selected pins agree
  p_steered_same_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (actSel == '0) || (actSel == steerMask));

  // R7: shutdown sets the flag
  p_shut_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    shutdownIn |=> shutFlag);

  // R7: shutdown silences the pins
  p_shut_pins_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    shutdownIn |=> (pinOut == idleLvl));

  // R8: automatic recovery clears the flag
  p_auto_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (shutFlag && restartAuto && !shutdownIn) |=> !shutFlag);

  // R9: manual recovery holds the flag until cleared
  p_manual_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (shutFlag && !restartAuto && !flagClear) |=> shutFlag);
endmodule

bind pwm_steer_stage pwm_steer_checker #(
  .NUM_PINS (NUM_PINS),
  .POL_W    (POL_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .steerMask   (steerMask),
  .polSel      (polSel),
  .restartAuto (restartAuto),
  .shutdownIn  (shutdownIn),
  .flagClear   (flagClear),
  .pinOut      (pinOut),
  .shutFlag    (shutFlag)
);

// File: tb/pwm_steer_stage_bench.sv
module pwm_steer_stage_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tickEn = 1'b0;
  logic       pwmIn = 1'b0;
  logic       periodStart = 1'b0;
  logic [3:0] steerMask = 4'h0;
  logic [1:0] polSel = 2'b00;
  logic [6:0] delayCount = 7'd0;
  logic       restartAuto = 1'b0;
  logic       shutdownIn = 1'b0;
  logic       flagClear = 1'b0;
  logic [3:0] pinOut;
  logic       shutFlag;

  int checks = 0;
  int errors = 0;
  bit expRun;
  bit expFlag;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_steer_stage u_pwm_steer_stage (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .pwmIn(pwmIn),
    .periodStart(periodStart), .steerMask(steerMask), .polSel(polSel),
    .delayCount(delayCount), .restartAuto(restartAuto),
    .shutdownIn(shutdownIn), .flagClear(flagClear),
    .pinOut(pinOut), .shutFlag(shutFlag)
  );

  function automatic logic [3:0] idleOf(input logic [1:0] p);
    return {p[1], p[0], p[1], p[0]};
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // One PWM period with pwmIn high for cycles 0..w-1; tick every div clocks
  task automatic runPulse(input string req, input logic [3:0] m, input logic [1:0] p,
                          input int d, input int w, input int per, input int div);
    bit bad = 0;
    logic [3:0] badAct = '0;
    logic [3:0] badExp = '0;
    int dEff = d * div;
    steerMask = m; polSel = p; delayCount = 7'(d);
    shutdownIn = 0; flagClear = 0; periodStart = 0; pwmIn = 0; tickEn = 1;
    @(negedge clk);
    for (int j = 0; j < per; j++) begin
      pwmIn = (j < w);
      periodStart = (j == 0);
      tickEn = ((j % div) == 0);
      @(negedge clk);
      begin
        logic [3:0] e;
        e = (((j >= dEff) && (j < w)) ? m : 4'h0) ^ idleOf(p);
        if (!bad && pinOut !== e) begin
          bad = 1; badAct = pinOut; badExp = e;
        end
      end
    end
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL %s mask=%b pol=%b d=%0d w=%0d actual=%b expected=%b",
               req, m, p, d, w, badAct, badExp);
    end
  endtask

  // One period with optional shutdown window [sa,sb] and flag clear at cl
  task automatic runShut(input string req, input logic [3:0] m, input logic [1:0] p,
                         input int sa, input int sb, input int cl, input bit au);
    bit badP = 0;
    bit badF = 0;
    logic [3:0] aP = '0;
    logic [3:0] eP = '0;
    bit aF = 0;
    bit eF = 0;
    steerMask = m; polSel = p; delayCount = 0; restartAuto = au; tickEn = 1;
    for (int j = 0; j < 12; j++) begin
      bit sh = (j >= sa) && (j <= sb);
      bit nF;
      bit nR;
      pwmIn = (j < 6);
      periodStart = (j == 0);
      shutdownIn = sh;
      flagClear = (j == cl);
      if (sh) nF = 1; else if (au || j == cl) nF = 0; else nF = expFlag;
      if (sh) nR = 0; else if (j == 0 && !expFlag) nR = 1; else nR = expRun;
      expFlag = nF; expRun = nR;
      @(negedge clk);
      begin
        logic [3:0] e;
        e = ((expRun && j < 6) ? m : 4'h0) ^ idleOf(p);
        if (!badP && pinOut !== e) begin badP = 1; aP = pinOut; eP = e; end
        if (!badF && shutFlag !== expFlag) begin badF = 1; aF = shutFlag; eF = expFlag; end
      end
    end
    shutdownIn = 0; flagClear = 0;
    checks += 2;
    if (badP) begin
      errors++;
      $display("FAIL %s pins actual=%b expected=%b", req, aP, eP);
    end
    if (badF) begin
      errors++;
      $display("FAIL %s flag actual=%b expected=%b", req, aF, eF);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 pins", pinOut, 4'h0);
    check("R11 flag", {3'b0, shutFlag}, 4'h0);
    polSel = 2'b11;
    #1;
    check("R3 idle active-low in reset", pinOut, 4'hF);
    polSel = 2'b00;
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 after reset", pinOut, 4'h0);
    expRun = 1; expFlag = 0;

    // R1 R2 R3 R4: every mask with every polarity, zero delay
    for (int pp = 0; pp < 4; pp++)
      for (int mm = 0; mm < 16; mm++)
        runPulse("R1 R2 R3 R4 steer sweep", 4'(mm), 2'(pp), 0, 5, 12, 1);

    // R5 R6: delay sweep across the suppression point, tick every clock
    for (int d = 0; d <= 12; d++)
      runPulse("R5 R6 delay sweep", 4'hF, 2'b01, d, 10, 16, 1);
    runPulse("R6 max delay suppressed", 4'hF, 2'b00, 127, 30, 34, 1);

    // R5: tick one clock in four
    for (int d = 0; d <= 4; d++)
      runPulse("R5 divided tick", 4'b1010, 2'b10, d, 14, 18, 4);

    // R7 R9 R10: manual recovery
    runShut("R10 normal manual", 4'hF, 2'b00, -1, -1, -1, 0);
    runShut("R7 shutdown manual", 4'hF, 2'b00, 2, 4, -1, 0);
    runShut("R9 flag held", 4'hF, 2'b00, -1, -1, -1, 0);
    runShut("R9 R10 clear mid-period", 4'hF, 2'b00, -1, -1, 7, 0);
    runShut("R10 resume after clear", 4'hF, 2'b00, -1, -1, -1, 0);

    // R7 R8 R10 R2: automatic recovery, partial mask, mixed polarity
    runShut("R7 R8 shutdown auto", 4'b0101, 2'b10, 2, 4, -1, 1);
    runShut("R8 R10 resume auto", 4'b0101, 2'b10, -1, -1, -1, 1);
    runShut("R7 R8 late shutdown", 4'hF, 2'b01, 9, 10, -1, 1);
    runShut("R10 resume after late", 4'hF, 2'b01, -1, -1, -1, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule